// File: doc/BRIEF.md
# Coprocessor Port Adapter

This block sits between a host processor's generic coprocessor port and an arithmetic core driven by a single-pulse go and done handshake. The host issues an operation in two phases. A one-cycle start carries a 10-bit opcode. A one-cycle load on the next edge carries two 64-bit operands. The adapter holds the opcode and the low halves of both operands, and it raises busy while the core works. It turns the host opcode into the core's 6-bit function code and starts the core with one go pulse.

When the core reports done, the adapter lowers busy first. On the following edge it presents the 64-bit result, two condition flags and an exception flag. The host can therefore treat the falling edge of busy as a one-cycle warning that new result values are about to appear. An opcode outside the supported set never reaches the core. It finishes as an exception with a zero result.

Top module: `cpa_port_adapter`

## Requirements
- R1: After reset, busy, core go, the result, both condition flags and the exception flag are all 0.
- R2: The opcode is sampled in the start cycle. Busy is high from the cycle after start (the load cycle) until the edge at which core done is sampled. In the cycle after that edge, busy is low.
- R3: The operands are sampled in the load cycle. Core inputs A and B carry bits 31..0 of the first and second operand and stay stable until done. Core go is high for exactly one cycle: the cycle after load.
- R4: An opcode is supported when bits 9..6 are zero and bits 5..0 (a 3-bit group in bits 5..3 and a 3-bit index in bits 2..0) are one of these codes: group 000 with any index except 011; group 001 with index 000 or 010; groups 010 to 111 with index 000 only. For a supported opcode, the core op output equals opcode bits 5..0.
- R5: The result, flags and exception flag change only on the edge that ends the first cycle with busy low. The new result has bits 31..0 equal to the core result and bits 63..32 equal to zero.
- R6: Condition flags are {N, Z}. Bit 1 is result bit 31 and bit 0 is 1 when result bits 31..0 are all zero.
- R7: An unsupported opcode produces no core go. Busy falls after the load edge, and one cycle later the result is 0, the exception flag is 1 and the flags read 01. A supported operation clears the exception flag.
- R8: A start arriving while busy is high is ignored. The core op does not change and no further operation follows.
- R9: The outputs hold their values between publications. A start in the cycle in which busy has just fallen is accepted while the previous result is being published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_start | input | 1 | One-cycle operation start from the host |
| hst_load | input | 1 | One-cycle operand strobe, the cycle after start |
| hst_opcode | input | 10 | Host opcode, valid with start |
| hst_op1 | input | 64 | First operand, valid with load |
| hst_op2 | input | 64 | Second operand, valid with load |
| hst_busy | output | 1 | Operation in progress |
| hst_result | output | 64 | Result, zero-extended from 32 bits |
| hst_cc | output | 2 | Condition flags {N, Z} |
| hst_exc | output | 1 | Exception, unsupported opcode |
| core_a | output | 32 | Core argument A |
| core_b | output | 32 | Core argument B |
| core_op | output | 6 | Core function code |
| core_go | output | 1 | One-cycle core start pulse |
| core_done | input | 1 | Core completion |
| core_res | input | 32 | Core result, valid with done |

## Verification
The embedded assertions check the handshake rules on every cycle. These rules are: busy is high whenever load is, busy only rises after a start, go is a single-cycle pulse, publication happens only with busy low, and a set exception flag always comes with a zero result. Other properties can only be shown by the bench's scenarios against its cycle model. These are: the full opcode decode over all 64 low codes and the upper-bit cases, the flag values for negative and zero results, truncation of the upper operand halves, starts that are ignored during an operation, back-to-back operations and long core latencies.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  localparam int CORE_OP_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WLOAD = 2'd1,
    ST_RUN   = 2'd2,
    ST_PUB   = 2'd3
  } cpa_state_e;

  // supported function codes: group in [5:3], index in [2:0]
  function automatic logic op_known(input logic [CORE_OP_W-1:0] code);
    logic [2:0] grp;
    logic [2:0] idx;
    grp = code[5:3];
    idx = code[2:0];
    case (grp)
      3'b000:  return idx != 3'b011;
      3'b001:  return (idx == 3'b000) || (idx == 3'b010);
      default: return idx == 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/cpa_decode.sv
module cpa_decode #(
  parameter int OPC_W = 10
) (
  input  logic [OPC_W-1:0]              opc,
  output logic [cpa_pkg::CORE_OP_W-1:0] core_op,
  output logic                          legal
);
  localparam int CW = cpa_pkg::CORE_OP_W;

  logic upper_clear;

  generate
    if (OPC_W > CW) begin : g_upper
      assign upper_clear = ~|opc[OPC_W-1:CW];
    end else begin : g_noupper
      assign upper_clear = 1'b1;
    end
  endgenerate

  assign core_op = opc[CW-1:0];
  assign legal   = upper_clear & cpa_pkg::op_known(opc[CW-1:0]);
endmodule

// File: rtl/cpa_ctrl.sv
module cpa_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic load,
  input  logic legal,
  input  logic core_done,
  output logic busy,
  output logic go,
  output logic take_opc,
  output logic take_ops,
  output logic fin_ok,
  output logic fin_err,
  output logic pub_en
);
  import cpa_pkg::*;

  cpa_state_e state;
  logic       open_slot;

  assign open_slot = (state == ST_IDLE) || (state == ST_PUB);
  assign take_opc  = start && open_slot;
  assign take_ops  = (state == ST_WLOAD);
  assign fin_ok    = (state == ST_RUN) && core_done;
  assign fin_err   = (state == ST_WLOAD) && !legal;
  assign pub_en    = (state == ST_PUB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      go    <= 1'b0;
    end else begin
      go <= 1'b0;
      case (state)
        ST_IDLE, ST_PUB: begin
          if (start) begin
            state <= ST_WLOAD;
            busy  <= 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WLOAD: begin
          if (legal) begin
            go    <= 1'b1;
            state <= ST_RUN;
          end else begin
            busy  <= 1'b0;
            state <= ST_PUB;
          end
        end
        ST_RUN: begin
          if (core_done) begin
            busy  <= 1'b0;
            state <= ST_PUB;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> busy);
  // R2
  load_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WLOAD) |-> load);
  // R3
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/cpa_publish.sv
module cpa_publish #(
  parameter int DW = 32,
  parameter int HW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_ok,
  input  logic          fin_err,
  input  logic          pub_en,
  input  logic          busy,
  input  logic [DW-1:0] core_res,
  output logic [HW-1:0] result,
  output logic [1:0]    cc,
  output logic          exc
);
  logic [DW-1:0] pend_res;
  logic          pend_err;
  logic [DW-1:0] res_q;

  function automatic logic [1:0] flags_of(input logic [DW-1:0] v);
    return {v[DW-1], ~|v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_res <= '0;
      pend_err <= 1'b0;
      res_q    <= '0;
      cc       <= 2'b00;
      exc      <= 1'b0;
    end else begin
      if (fin_ok) begin
        pend_res <= core_res;
        pend_err <= 1'b0;
      end else if (fin_err) begin
        pend_res <= '0;
        pend_err <= 1'b1;
      end
      if (pub_en) begin
        res_q <= pend_res;
        exc   <= pend_err;
        cc    <= flags_of(pend_res);
      end
    end
  end

  generate
    if (HW > DW) begin : g_pad
      assign result = {{(HW-DW){1'b0}}, res_q};
    end else begin : g_cut
      assign result = res_q[HW-1:0];
    end
  endgenerate

  // R5
  pub_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pub_en |-> !busy);
  // R5
  fall_pub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pub_en);
  // R7
  exc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (result == '0));
endmodule

// File: rtl/cpa_port_adapter.sv
module cpa_port_adapter #(
  parameter int OPC_W = 10,
  parameter int HW    = 64,
  parameter int DW    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hst_start,
  input  logic                          hst_load,
  input  logic [OPC_W-1:0]              hst_opcode,
  input  logic [HW-1:0]                 hst_op1,
  input  logic [HW-1:0]                 hst_op2,
  output logic                          hst_busy,
  output logic [HW-1:0]                 hst_result,
  output logic [1:0]                    hst_cc,
  output logic                          hst_exc,
  output logic [DW-1:0]                 core_a,
  output logic [DW-1:0]                 core_b,
  output logic [cpa_pkg::CORE_OP_W-1:0] core_op,
  output logic                          core_go,
  input  logic                          core_done,
  input  logic [DW-1:0]                 core_res
);
  logic [OPC_W-1:0] opc_q;
  logic [DW-1:0]    a_q;
  logic [DW-1:0]    b_q;
  logic             legal;
  logic             take_opc;
  logic             take_ops;
  logic             fin_ok;
  logic             fin_err;
  logic             pub_en;

  generate
    if (HW > DW) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^{hst_op1[HW-1:DW], hst_op2[HW-1:DW]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      if (take_opc) opc_q <= hst_opcode;
      if (take_ops) begin
        a_q <= hst_op1[DW-1:0];
        b_q <= hst_op2[DW-1:0];
      end
    end
  end

  cpa_decode #(.OPC_W(OPC_W)) u_dec (
    .opc     (opc_q),
    .core_op (core_op),
    .legal   (legal)
  );

  cpa_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (hst_start),
    .load      (hst_load),
    .legal     (legal),
    .core_done (core_done),
    .busy      (hst_busy),
    .go        (core_go),
    .take_opc  (take_opc),
    .take_ops  (take_ops),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err),
    .pub_en    (pub_en)
  );

  cpa_publish #(.DW(DW), .HW(HW)) u_pub (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_ok   (fin_ok),
    .fin_err  (fin_err),
    .pub_en   (pub_en),
    .busy     (hst_busy),
    .core_res (core_res),
    .result   (hst_result),
    .cc       (hst_cc),
    .exc      (hst_exc)
  );

  assign core_a = a_q;
  assign core_b = b_q;

  // R3
  arg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_busy && !take_ops && !core_go) |-> ($stable(core_a) && $stable(core_b)));
  // R8
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_busy && $past(hst_busy)) |-> $stable(core_op));
endmodule

// File: tb/tb_cpa_port_adapter.sv
module tb_cpa_port_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_start = 1'b0;
  logic        hst_load = 1'b0;
  logic [9:0]  hst_opcode = '0;
  logic [63:0] hst_op1 = '0;
  logic [63:0] hst_op2 = '0;
  logic        hst_busy;
  logic [63:0] hst_result;
  logic [1:0]  hst_cc;
  logic        hst_exc;
  logic [31:0] core_a;
  logic [31:0] core_b;
  logic [5:0]  core_op;
  logic        core_go;
  logic        core_done = 1'b0;
  logic [31:0] core_res = '0;

  always #10 clk = ~clk;

  cpa_port_adapter dut (
    .clk(clk), .rst_n(rst_n), .hst_start(hst_start), .hst_load(hst_load),
    .hst_opcode(hst_opcode), .hst_op1(hst_op1), .hst_op2(hst_op2),
    .hst_busy(hst_busy), .hst_result(hst_result), .hst_cc(hst_cc), .hst_exc(hst_exc),
    .core_a(core_a), .core_b(core_b), .core_op(core_op), .core_go(core_go),
    .core_done(core_done), .core_res(core_res)
  );

  int checks = 0;
  int errs = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit good_code(input logic [9:0] o);
    logic [5:0] ok_list[15] = '{6'o00, 6'o01, 6'o02, 6'o04, 6'o05, 6'o06, 6'o07,
                                6'o10, 6'o12, 6'o20, 6'o30, 6'o40, 6'o50, 6'o60, 6'o70};
    if (o[9:6] != 4'b0) return 0;
    foreach (ok_list[i]) if (ok_list[i] == o[5:0]) return 1;
    return 0;
  endfunction

  // behavioural model: phase 0 idle, 1 waiting operands, 2 core running, 3 publishing
  int          m_ph = 0;
  logic        m_busy = 0, m_go = 0, m_exc = 0;
  logic [63:0] m_res = '0;
  logic [1:0]  m_cc = '0;
  logic [9:0]  m_opc = '0;
  logic [31:0] m_a = '0, m_b = '0, p_res = '0;
  logic        p_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_busy = 0; m_go = 0; m_exc = 0; m_res = '0; m_cc = '0;
      p_res = '0; p_err = 0;
    end else begin
      m_go = 0;
      case (m_ph)
        0, 3: begin
          if (m_ph == 3) begin
            m_res = {32'h0, p_res};
            m_exc = p_err;
            m_cc  = {p_res[31], (p_res == 32'h0)};
          end
          if (hst_start) begin m_opc = hst_opcode; m_busy = 1; m_ph = 1; end
          else m_ph = 0;
        end
        1: begin
          m_a = hst_op1[31:0]; m_b = hst_op2[31:0];
          if (good_code(m_opc)) begin m_go = 1; m_ph = 2; end
          else begin p_res = 0; p_err = 1; m_busy = 0; m_ph = 3; end
        end
        default: begin
          if (core_done) begin p_res = core_res; p_err = 0; m_busy = 0; m_ph = 3; end
        end
      endcase
    end
  end

  // stand-in core with configurable latency
  int lat_cfg = 3;
  int core_cnt = 0;
  logic [31:0] core_val = '0;
  always @(negedge clk) begin
    if (core_go) begin
      core_cnt = lat_cfg;
      core_val = (core_op == 6'o50) ? core_a * core_b : core_a - core_b;
    end else if (core_cnt > 0) core_cnt--;
    core_done = (core_cnt == 1);
    core_res  = core_done ? core_val : 32'hDEAD_BEEF;
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R2 busy", {63'b0, hst_busy}, {63'b0, m_busy});
      chk("R3 core_go", {63'b0, core_go}, {63'b0, m_go});
      chk("R5 result", hst_result, m_res);
      chk("R6 cc", {62'b0, hst_cc}, {62'b0, m_cc});
      chk("R7 exc", {63'b0, hst_exc}, {63'b0, m_exc});
      if (m_ph == 2) begin
        chk("R3 core_a", {32'b0, core_a}, {32'b0, m_a});
        chk("R3 core_b", {32'b0, core_b}, {32'b0, m_b});
        chk("R4 core_op", {58'b0, core_op}, {58'b0, m_opc[5:0]});
      end
    end
  end

  // called at a negedge; returns at a negedge
  task automatic run_op(input logic [9:0] opc, input logic [63:0] a, input logic [63:0] b,
                        input int lat, input bit inject, input bit b2b);
    lat_cfg = lat;
    hst_start = 1; hst_opcode = opc;
    @(negedge clk);
    hst_start = 0; hst_load = 1; hst_op1 = a; hst_op2 = b;
    @(negedge clk);
    hst_load = 0;
    if (inject && hst_busy) begin
      hst_start = 1; hst_opcode = ~opc;
      @(negedge clk);
      hst_start = 0;
    end
    while (m_ph != (b2b ? 3 : 0)) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1;
      errs++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'b0, hst_busy}, 64'h0);
    chk("R1 result", hst_result, 64'h0);
    chk("R1 cc", {62'b0, hst_cc}, 64'h0);
    chk("R1 exc", {63'b0, hst_exc}, 64'h0);
    chk("R1 go", {63'b0, core_go}, 64'h0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);

    run_op(10'o000, 64'd5, 64'd3, 3, 0, 0);
    chk("R5 sin result", hst_result, 64'd2);
    run_op(10'o050, 64'd7, 64'd6, 4, 0, 0);
    chk("R5 mul result", hst_result, 64'd42);
    run_op(10'o001, 64'd3, 64'd9, 2, 0, 0);
    chk("R6 negative flags", {62'b0, hst_cc}, 64'b10);
    run_op(10'o060, 64'd4, 64'd4, 5, 0, 0);
    chk("R6 zero flags", {62'b0, hst_cc}, 64'b01);
    run_op(10'o003, 64'd8, 64'd1, 3, 0, 0);
    chk("R7 exc low code", {63'b0, hst_exc}, 64'h1);
    chk("R7 result zero", hst_result, 64'h0);
    run_op(10'b10_0000_0000, 64'd8, 64'd1, 3, 0, 0);
    chk("R7 exc upper bit", {63'b0, hst_exc}, 64'h1);
    run_op(10'o012, 64'hFFFF_0000_0000_0012, 64'hABCD_0000_0000_0002, 3, 0, 0);
    chk("R3 upper half dropped", hst_result, 64'h10);
    chk("R7 exc cleared", {63'b0, hst_exc}, 64'h0);
    run_op(10'o020, 64'd30, 64'd10, 6, 1, 0);
    repeat (3) @(negedge clk);
    chk("R8 no extra op", {63'b0, hst_busy}, 64'h0);
    chk("R8 result kept", hst_result, 64'd20);
    run_op(10'o040, 64'd100, 64'd1, 3, 0, 1);
    run_op(10'o070, 64'd50, 64'd8, 2, 0, 0);
    chk("R9 back to back", hst_result, 64'd42);
    repeat (4) @(negedge clk);
    chk("R9 hold", hst_result, 64'd42);
    run_op(10'o007, 64'd9, 64'd2, 40, 0, 0);
    chk("R2 long latency", hst_result, 64'd7);
    for (int c = 0; c < 64; c++) begin
      run_op({4'b0, c[5:0]}, 64'(c + 3), 64'd1, 2, 0, 0);
      // R4 decode coverage
      chk("R4 legality", {63'b0, hst_exc}, {63'b0, !good_code({4'b0, c[5:0]})});
    end
    repeat (3) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule